// File: doc/BRIEF.md
# ADC Output Code Formatter

This block sits between the raw result of a pipelined converter core and the parallel output pads. Each clock it accepts a 13-bit offset-binary sample together with over-range and under-range indications from the converter. Out-of-range samples are replaced by saturated codes, the word is converted to two's complement when a static format input asks for it, and the result is delayed through a fixed pipeline before it reaches the output bus. The offset correction in the core centres a zero differential input on mid-scale code 4096, which the formatter leaves unchanged in offset-binary mode.

Alongside the data bus the block drives an out-of-range flag that stays aligned with its sample, a pad output-enable for the data bus, and an output clock for the receiver. The output clock is the inverted sampling clock, so its rising edge falls in the middle of each data word. A power-down request clears the pipeline and holds the data bus and flag at zero. A disable request turns off the data pad drivers, and it takes precedence over power-down.

Top module: `adc_code_fmt`

## Requirements
- R1: With both range indications low and `twos_sel` low, a raw code passes through unchanged. Raw 0x1000 (4096, zero input) appears as 0x1000.
- R2: With `twos_sel` high, the output code is the offset-binary code with bit 12 (the MSB) inverted. For example, 0x1000 becomes 0x0000 and 0x0001 becomes 0x1001.
- R3: When `over_rng` is high, the offset-binary code is forced to 0x1FFF and `oor_flag` is 1.
- R4: When `under_rng` is high and `over_rng` is low, the offset-binary code is forced to 0x0000 and `oor_flag` is 1.
- R5: Saturation is applied before format conversion. In two's complement an over-range gives 0x0FFF and an under-range gives 0x1000.
- R6: A sample present before a rising edge appears on `data_out` and `oor_flag` just after the 12th rising edge, counting that edge as the first. The flag and the data always belong to the same sample.
- R7: `out_dis` high drives `data_oe` low. While the data pads are disabled, `oor_flag` continues to follow the pipeline.
- R8: While `power_down` is high, `data_out` and `oor_flag` are 0. Every edge with `power_down` high clears the pipeline, so after release both outputs stay 0 for 12 edges.
- R9: When `power_down` and `out_dis` are both high, `data_oe` is low.
- R10: `dclk_out` is the inverse of `clk`: it is high while `clk` is low and low while `clk` is high.
- R11: During reset and right after it, `data_out` is 0, `oor_flag` is 0 and `data_oe` follows `out_dis`.
- R12: When both range indications are high, over-range wins and the offset-binary code is 0x1FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; only its rising edge is used |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_down | input | 1 | High: clear the pipeline and force the outputs to zero |
| out_dis | input | 1 | High: disable the data pad drivers |
| twos_sel | input | 1 | 0: offset binary, 1: two's complement |
| raw_code | input | 13 | Offset-binary sample from the converter |
| over_rng | input | 1 | Sample is above full scale |
| under_rng | input | 1 | Sample is below full scale |
| data_out | output | 13 | Formatted, delayed data word |
| data_oe | output | 1 | Output enable for the data pads |
| oor_flag | output | 1 | Out-of-range flag, aligned with `data_out` |
| dclk_out | output | 1 | Output clock for the receiver (inverted `clk`) |

## Verification
On every edge, the embedded assertions check the first pipeline stage against the previous cycle's inputs. This covers the pass-through and MSB inversion, over-range saturation in both formats, and clearing of the pipeline end after power-down. They also check that power-down keeps the outputs quiet. The full twelve-edge latency, the alignment of the flag with its word, zero flushing after power-down and the precedence of the pad disable are shown only by the bench. Its queue model compares every output on every clock, and it adds directed scenarios such as a single marker sample travelling through an idle pipeline.

// File: rtl/adc_fmt_pkg.sv
`timescale 1ns/1ps
package adc_fmt_pkg;
   localparam int unsigned CODE_W_DEF  = 13;
   localparam int unsigned LATENCY_DEF = 12;

   typedef enum logic {
      FMT_OFFSET = 1'b0,
      FMT_TWOS   = 1'b1
   } fmt_e;
endpackage

// File: rtl/code_shaper.sv
`timescale 1ns/1ps
// Saturation of out-of-range samples followed by format conversion.
module code_shaper
   import adc_fmt_pkg::*;
#(
   parameter int unsigned W = CODE_W_DEF
) (
   input  logic [W-1:0] raw_i,
   input  logic         over_i,
   input  logic         under_i,
   input  fmt_e         fmt_i,
   output logic [W-1:0] code_o,
   output logic         flag_o
);
   localparam logic [W-1:0] FULL_CODE = {W{1'b1}};
   localparam logic [W-1:0] ZERO_CODE = '0;
   localparam logic [W-1:0] MSB_MASK  = {1'b1, {(W-1){1'b0}}};

   generate
      if (W < 2) begin : g_bad_width
         $error("code_shaper: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] sat_code;

   // over-range has priority over under-range
   always_comb begin
      if (over_i)       sat_code = FULL_CODE;
      else if (under_i) sat_code = ZERO_CODE;
      else              sat_code = raw_i;
   end

   always_comb begin
      code_o = (fmt_i == FMT_TWOS) ? (sat_code ^ MSB_MASK) : sat_code;
      flag_o = over_i | under_i;
   end
endmodule

// File: rtl/align_pipe.sv
`timescale 1ns/1ps
// Fixed-latency delay line with synchronous clear.
module align_pipe #(
   parameter int unsigned W     = 14,
   parameter int unsigned DEPTH = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] first_o,
   output logic [W-1:0] q_o
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("align_pipe: DEPTH must be at least 1");
      end
   endgenerate

   logic [W-1:0] stage_q [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         logic [W-1:0] stage_d;
         if (i == 0) begin : g_head
            assign stage_d = d_i;
         end else begin : g_body
            assign stage_d = stage_q[i-1];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     stage_q[i] <= '0;
            else if (clr_i) stage_q[i] <= '0;
            else            stage_q[i] <= stage_d;
         end
      end
   endgenerate

   assign first_o = stage_q[0];
   assign q_o     = stage_q[DEPTH-1];
endmodule

// File: rtl/out_stage.sv
`timescale 1ns/1ps
// Power-down forcing and pad enable for the data bus.
module out_stage #(
   parameter int unsigned W = 13
) (
   input  logic         clk,
   input  logic         power_down_i,
   input  logic         out_dis_i,
   input  logic [W-1:0] code_i,
   input  logic         flag_i,
   output logic [W-1:0] data_o,
   output logic         flag_o,
   output logic         oe_o,
   output logic         dclk_o
);
   always_comb begin
      data_o = power_down_i ? '0 : code_i;
      flag_o = power_down_i ? 1'b0 : flag_i;
      oe_o   = ~out_dis_i;   // disable wins over power-down
   end

   assign dclk_o = ~clk;
endmodule

// File: rtl/adc_code_fmt.sv
`timescale 1ns/1ps
module adc_code_fmt
   import adc_fmt_pkg::*;
#(
   parameter int unsigned CODE_W  = CODE_W_DEF,
   parameter int unsigned LATENCY = LATENCY_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              power_down,
   input  logic              out_dis,
   input  logic              twos_sel,
   input  logic [CODE_W-1:0] raw_code,
   input  logic              over_rng,
   input  logic              under_rng,
   output logic [CODE_W-1:0] data_out,
   output logic              data_oe,
   output logic              oor_flag,
   output logic              dclk_out
);
   localparam int unsigned PW = CODE_W + 1;
   localparam logic [CODE_W-1:0] MSB_MASK = {1'b1, {(CODE_W-1){1'b0}}};
   localparam logic [CODE_W-1:0] ALL_ONES = {CODE_W{1'b1}};

   generate
      if (LATENCY < 1) begin : g_bad_lat
         $error("adc_code_fmt: LATENCY must be at least 1");
      end
   endgenerate

   fmt_e              fmt_sel;
   logic [CODE_W-1:0] shaped_code;
   logic              shaped_flag;
   logic [PW-1:0]     first_q;
   logic [PW-1:0]     last_q;

   assign fmt_sel = twos_sel ? FMT_TWOS : FMT_OFFSET;

   code_shaper #(.W(CODE_W)) shaper_i (
      .raw_i   (raw_code),
      .over_i  (over_rng),
      .under_i (under_rng),
      .fmt_i   (fmt_sel),
      .code_o  (shaped_code),
      .flag_o  (shaped_flag)
   );

   align_pipe #(.W(PW), .DEPTH(LATENCY)) pipe_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (power_down),
      .d_i     ({shaped_flag, shaped_code}),
      .first_o (first_q),
      .q_o     (last_q)
   );

   out_stage #(.W(CODE_W)) drive_i (
      .clk          (clk),
      .power_down_i (power_down),
      .out_dis_i    (out_dis),
      .code_i       (last_q[CODE_W-1:0]),
      .flag_i       (last_q[CODE_W]),
      .data_o       (data_out),
      .flag_o       (oor_flag),
      .oe_o         (data_oe),
      .dclk_o       (dclk_out)
   );

   // R1 / R2: in-range samples enter the pipe with only the MSB possibly flipped
   a_r2_fmt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(power_down) && !$past(over_rng) && !$past(under_rng))
      |-> (first_q == {1'b0, $past(raw_code) ^ ($past(twos_sel) ? MSB_MASK : '0)}));

   // R3 / R5: over-range saturates before the format conversion
   a_r3_over_full: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(power_down) && $past(over_rng))
      |-> (first_q == {1'b1, ALL_ONES ^ ($past(twos_sel) ? MSB_MASK : '0)}));

   // R8: outputs quiet during power-down
   a_r8_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      power_down |-> (data_out == '0 && !oor_flag));

   // R8: an edge with power-down leaves the pipe end cleared
   a_r8_pipe_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(power_down)) |-> (last_q == '0));
endmodule

// File: tb/adc_code_fmt_tb.sv
`timescale 1ns/1ps
module adc_code_fmt_tb_top;
   localparam int LAT = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        power_down = 1'b0;
   logic        out_dis = 1'b0;
   logic        twos_sel = 1'b0;
   logic [12:0] raw_code = '0;
   logic        over_rng = 1'b0;
   logic        under_rng = 1'b0;
   logic [12:0] data_out;
   logic        data_oe;
   logic        oor_flag;
   logic        dclk_out;

   int    n_run = 0;
   int    n_fail = 0;
   string cur_req = "R11";
   bit    done = 1'b0;
   logic [13:0] mq [$];

   always #10 clk = ~clk;

   adc_code_fmt dut_i (
      .clk(clk), .rst_n(rst_n), .power_down(power_down), .out_dis(out_dis),
      .twos_sel(twos_sel), .raw_code(raw_code), .over_rng(over_rng),
      .under_rng(under_rng), .data_out(data_out), .data_oe(data_oe),
      .oor_flag(oor_flag), .dclk_out(dclk_out)
   );

   function automatic logic [13:0] ref_fmt(logic [12:0] s, logic o, logic u, logic t);
      logic [12:0] c;
      if (o)      c = 13'h1FFF;
      else if (u) c = 13'h0000;
      else        c = s;
      if (t) c[12] = ~c[12];
      return {o | u, c};
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   initial begin
      for (int i = 0; i < LAT; i++) mq.push_back('0);
   end

   // reference model: one entry per rising edge
   always @(posedge clk) begin
      if (!rst_n || power_down) begin
         mq.delete();
         for (int i = 0; i < LAT; i++) mq.push_back('0);
      end else begin
         mq.push_back(ref_fmt(raw_code, over_rng, under_rng, twos_sel));
         void'(mq.pop_front());
      end
   end

   // cycle-by-cycle comparison
   always @(negedge clk) begin
      if (!done) begin
         logic [13:0] e;
         e = power_down ? 14'h0 : mq[0];
         chk(cur_req, "data_out", 32'(data_out), 32'(e[12:0]));
         chk(cur_req, "oor_flag", 32'(oor_flag), 32'(e[13]));
         chk(cur_req, "data_oe", 32'(data_oe), 32'(!out_dis));
      end
   end

   task automatic drive(logic [12:0] s, logic o, logic u, logic t);
      @(negedge clk); #1;
      raw_code = s; over_rng = o; under_rng = u; twos_sel = t;
   endtask

   task automatic hold(int n);
      for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      // R11: reset state
      cur_req = "R11";
      raw_code = 13'h1555;
      #35;
      chk("R11", "data_out in reset", 32'(data_out), 32'h0);
      chk("R11", "oor_flag in reset", 32'(oor_flag), 32'h0);
      chk("R11", "data_oe in reset", 32'(data_oe), 32'h1);
      @(negedge clk); #1; rst_n = 1'b1;
      hold(3);
      chk("R11", "data_out after reset", 32'(data_out), 32'h0);

      // R1: mid-scale zero input in offset binary
      cur_req = "R1";
      drive(13'h1000, 0, 0, 0);
      hold(LAT + 1);
      chk("R1", "mid-scale code", 32'(data_out), 32'h1000);

      // R2: two's complement inverts the MSB
      cur_req = "R2";
      drive(13'h1000, 0, 0, 1);
      drive(13'h0001, 0, 0, 1);
      hold(LAT);
      chk("R2", "0x0001 in twos", 32'(data_out), 32'h1001);
      drive(13'h1ABC, 0, 0, 1);
      drive(13'h0123, 0, 0, 0);
      hold(LAT);

      // R3: over-range offset binary
      cur_req = "R3";
      drive(13'h0042, 1, 0, 0);
      hold(LAT);
      chk("R3", "over code", 32'(data_out), 32'h1FFF);
      chk("R3", "over flag", 32'(oor_flag), 32'h1);

      // R4: under-range offset binary
      cur_req = "R4";
      drive(13'h1F00, 0, 1, 0);
      hold(LAT);
      chk("R4", "under code", 32'(data_out), 32'h0000);
      chk("R4", "under flag", 32'(oor_flag), 32'h1);

      // R5: saturation before conversion
      cur_req = "R5";
      drive(13'h0777, 1, 0, 1);
      hold(LAT);
      chk("R5", "over in twos", 32'(data_out), 32'h0FFF);
      drive(13'h0777, 0, 1, 1);
      hold(LAT);
      chk("R5", "under in twos", 32'(data_out), 32'h1000);

      // R12: both indications, over wins
      cur_req = "R12";
      drive(13'h0333, 1, 1, 0);
      hold(LAT);
      chk("R12", "both high", 32'(data_out), 32'h1FFF);

      // R6: single marker through a quiet pipe, and flag alignment
      cur_req = "R6";
      drive(13'h0000, 0, 0, 0);
      hold(LAT + 1);
      drive(13'h0ABC, 0, 0, 0);
      drive(13'h0000, 0, 0, 0);
      for (int i = 0; i < LAT - 2; i++) @(negedge clk);
      chk("R6", "marker not yet at edge 11", 32'(data_out), 32'h0000);
      @(negedge clk);
      chk("R6", "marker at edge 12", 32'(data_out), 32'h0ABC);
      #1;
      for (int k = 0; k < 30; k++)
         drive(13'((k * 389) & 13'h1FFF), (k % 7) == 3, (k % 5) == 1, k[0]);

      // R7: pad disable, flag still flows
      cur_req = "R7";
      out_dis = 1'b1;
      drive(13'h0100, 1, 0, 0);
      hold(LAT);
      chk("R7", "oe off", 32'(data_oe), 32'h0);
      chk("R7", "flag during disable", 32'(oor_flag), 32'h1);
      out_dis = 1'b0;

      // R8: power-down forcing and flush
      cur_req = "R8";
      drive(13'h1234, 0, 0, 0);
      hold(LAT);
      power_down = 1'b1;
      @(negedge clk);
      chk("R8", "data during pd", 32'(data_out), 32'h0);
      #1;
      hold(3);
      power_down = 1'b0;
      for (int i = 0; i < LAT - 1; i++) @(negedge clk);
      chk("R8", "zero flush after release", 32'(data_out), 32'h0);
      @(negedge clk);
      chk("R8", "data back after flush", 32'(data_out), 32'h1234);
      #1;

      // R9: disable beats power-down
      cur_req = "R9";
      power_down = 1'b1; out_dis = 1'b1;
      @(negedge clk);
      chk("R9", "oe with pd and disable", 32'(data_oe), 32'h0);
      #1;
      power_down = 1'b0; out_dis = 1'b0;

      // R10: output clock
      cur_req = "R10";
      @(negedge clk); #1;
      chk("R10", "dclk while clk low", 32'(dclk_out), 32'h1);
      @(posedge clk); #1;
      chk("R10", "dclk while clk high", 32'(dclk_out), 32'h0);

      hold(LAT + 2);
      finish_run();
   end
endmodule